// File: doc/BRIEF.md
# Phase-Weighted Sample Accumulator

The block folds several complex measurement samples into one result for each measurement stage. The samples are taken with the source set to evenly spaced phase offsets. Each sample arrives with a stage index and a phase index k. The block multiplies both the I and the Q component by the weight cos(2πk/N). It then adds the products into a running sum that belongs to that stage only. When the last phase of a point arrives for a stage, the block scales the sum back to sample units, presents it on the result port for one cycle and empties that stage's sum. The next point therefore starts from zero.

The phase count input selects the mode. A value of 0 turns combining off, and every sample is copied straight to the output. A value of 2 gives the two-phase differential case: the first sample minus the second, with no rounding at all. The values 3 to 7 spread the phases over a full turn. A sample whose phase index is not below the phase count is dropped, and a sticky error flag is raised.

Top module: `phase_weighted_accum`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` and `phase_err` are 0. Every stage sum is empty, so a point that was under way when reset came is forgotten.
- R2: For N = `phase_count` in 1..7, the weight of phase k is w = round(32768·cos(2πk/N)). Each result component is floor(Σ sample·w / 32768), taken over that point's samples. I and Q use the same weight and are summed separately.
- R3: With N = 2, the result is exactly the phase-0 sample minus the phase-1 sample, for both I and Q.
- R4: Each value of the 2-bit `smp_stage` has its own sum. Samples for different stages may be interleaved without affecting each other's results.
- R5: `res_valid` is high in the cycle after a sample with k = N−1 is accepted. `res_stage` then equals that sample's stage, and that stage's sum is cleared, so its next point starts fresh.
- R6: `res_valid` is low in any cycle that does not follow an accepted completing sample or a pass-through sample.
- R7: With N = 0, each valid sample appears sign-extended on `res_i`/`res_q` one cycle later, with `res_valid` high and its stage on `res_stage`. The phase index is ignored and the stage sums are left unchanged.
- R8: With N ≥ 1, a sample with k ≥ N produces no result and leaves every sum unchanged. It also sets `phase_err`, which stays 1 until reset.
- R9: With N = 7, full-scale samples whose signs match their weights produce the exact expected result with no wrap-around (magnitude above 2^17).
- R10: With N = 1, each k = 0 sample is output unchanged one cycle later, and any k ≥ 1 sample is dropped as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_i | input | 16 | Signed in-phase sample |
| smp_q | input | 16 | Signed quadrature sample |
| smp_stage | input | 2 | Measurement stage of the sample |
| smp_phase | input | 3 | Phase index k of the sample |
| phase_count | input | 3 | N: 0 = pass-through, 1..7 = number of phases |
| res_valid | output | 1 | Result strobe, one cycle per result |
| res_stage | output | 2 | Stage the result belongs to |
| res_i | output | 19 | Signed combined in-phase result |
| res_q | output | 19 | Signed combined quadrature result |
| phase_err | output | 1 | Sticky flag: a sample with an out-of-range phase was seen |

## Verification
The assertions assume that `phase_count` is held constant while any stage has a point in progress. They also assume that each stage's phase N−1 is the last sample of its point, because that sample is what closes the point. The stimulus sends the phases of every point in ascending order and changes the phase count only between points, with one exception. Between points, and between two phases of an open point, it injects pass-through samples, out-of-range phases and a mid-point reset. These show that such samples leave the open sums untouched.

// File: rtl/pwa_pkg.sv
`timescale 1ns/1ps
package pwa_pkg;

  // Phase index and phase count share this width: N is at most 7.
  localparam int unsigned PH_W     = 3;
  // Weight: signed, 15 fraction bits, one spare integer bit so +1.0 is exact.
  localparam int unsigned WGT_FRAC = 15;
  localparam int unsigned WGT_W    = WGT_FRAC + 2;
  // Guard bits so that seven full-scale products cannot overflow.
  localparam int unsigned GUARD_W  = 3;

  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_ADD    = 3'd1,
    ACT_FINISH = 3'd2,
    ACT_PASS   = 3'd3,
    ACT_DROP   = 3'd4
  } act_e;

  // round(32768 * cos(2*pi*k/n)); zero outside the legal range.
  function automatic logic signed [WGT_W-1:0] cos_weight(
    input logic [PH_W-1:0] n,
    input logic [PH_W-1:0] k
  );
    logic signed [WGT_W-1:0] w;
    case ({n, k})
      6'o10: w = 17'sd32768;
      6'o20: w = 17'sd32768;
      6'o21: w = -17'sd32768;
      6'o30: w = 17'sd32768;
      6'o31: w = -17'sd16384;
      6'o32: w = -17'sd16384;
      6'o40: w = 17'sd32768;
      6'o41: w = 17'sd0;
      6'o42: w = -17'sd32768;
      6'o43: w = 17'sd0;
      6'o50: w = 17'sd32768;
      6'o51: w = 17'sd10126;
      6'o52: w = -17'sd26510;
      6'o53: w = -17'sd26510;
      6'o54: w = 17'sd10126;
      6'o60: w = 17'sd32768;
      6'o61: w = 17'sd16384;
      6'o62: w = -17'sd16384;
      6'o63: w = -17'sd32768;
      6'o64: w = -17'sd16384;
      6'o65: w = 17'sd16384;
      6'o70: w = 17'sd32768;
      6'o71: w = 17'sd20431;
      6'o72: w = -17'sd7292;
      6'o73: w = -17'sd29523;
      6'o74: w = -17'sd29523;
      6'o75: w = -17'sd7292;
      6'o76: w = 17'sd20431;
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/pwa_rst_sync.sv
`timescale 1ns/1ps
module pwa_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/pwa_weight_rom.sv
`timescale 1ns/1ps
module pwa_weight_rom
  import pwa_pkg::*;
(
  input  logic [PH_W-1:0]         count,
  input  logic [PH_W-1:0]         phase,
  output logic signed [WGT_W-1:0] weight,
  output logic                    phase_ok,
  output logic                    phase_last
);

  always_comb begin
    weight     = cos_weight(count, phase);
    phase_ok   = (phase < count);
    phase_last = (count != '0) && (phase == count - PH_W'(1));
  end

endmodule

// File: rtl/pwa_ctrl.sv
`timescale 1ns/1ps
module pwa_ctrl
  import pwa_pkg::*;
#(
  parameter int unsigned STAGE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic [STAGE_W-1:0] smp_stage,
  input  logic [PH_W-1:0]    count,
  input  logic               phase_ok,
  input  logic               phase_last,
  output act_e               act,
  output logic               res_valid,
  output logic [STAGE_W-1:0] res_stage,
  output logic               phase_err
);

  logic               valid_d;
  logic               err_d;
  logic               stage_en;
  logic [STAGE_W-1:0] stage_q;
  logic               valid_q;
  logic               err_q;

  // Next-state logic
  always_comb begin
    if (!smp_valid)          act = ACT_NONE;
    else if (count == '0)    act = ACT_PASS;
    else if (!phase_ok)      act = ACT_DROP;
    else if (phase_last)     act = ACT_FINISH;
    else                     act = ACT_ADD;

    valid_d  = (act == ACT_PASS) || (act == ACT_FINISH);
    stage_en = valid_d;
    err_d    = err_q || (act == ACT_DROP);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= smp_stage;
  end

  assign res_valid = valid_q;
  assign res_stage = stage_q;
  assign phase_err = err_q;

  // R5
  finish_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && count != '0 && phase_ok && phase_last)
    |=> (res_valid && res_stage == $past(smp_stage)));

  // R8
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && count != '0 && !phase_ok) |=> (!res_valid && phase_err));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_err |=> phase_err);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !res_valid);

  // R7
  pass_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && count == '0) |=> (res_valid && res_stage == $past(smp_stage)));

endmodule

// File: rtl/pwa_lane.sv
`timescale 1ns/1ps
module pwa_lane
  import pwa_pkg::*;
#(
  parameter int unsigned SMP_W   = 16,
  parameter int unsigned STAGE_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  act_e                          act,
  input  logic [STAGE_W-1:0]            stage,
  input  logic signed [SMP_W-1:0]       sample,
  input  logic signed [WGT_W-1:0]       weight,
  output logic signed [SMP_W+GUARD_W-1:0] result
);

  localparam int unsigned STAGES = 1 << STAGE_W;
  localparam int unsigned ACC_W  = SMP_W + WGT_W + GUARD_W;
  localparam int unsigned OUT_W  = SMP_W + GUARD_W;

  logic signed [ACC_W-1:0] sample_x;
  logic signed [ACC_W-1:0] weight_x;
  logic signed [ACC_W-1:0] prod;
  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] acc_d;
  logic signed [ACC_W-1:0] acc_q [STAGES];
  logic [STAGES-1:0]       acc_en;
  logic signed [OUT_W-1:0] result_d;
  logic signed [OUT_W-1:0] result_q;
  logic                    result_en;
  logic                    summing;

  // Next-state logic
  always_comb begin
    sample_x  = {{(ACC_W-SMP_W){sample[SMP_W-1]}}, sample};
    weight_x  = {{(ACC_W-WGT_W){weight[WGT_W-1]}}, weight};
    prod      = sample_x * weight_x;
    sum       = acc_q[stage] + prod;
    summing   = (act == ACT_ADD) || (act == ACT_FINISH);
    acc_d     = (act == ACT_FINISH) ? '0 : sum;
    result_en = (act == ACT_FINISH) || (act == ACT_PASS);
    if (act == ACT_PASS) result_d = {{GUARD_W{sample[SMP_W-1]}}, sample};
    else                 result_d = sum[WGT_FRAC +: OUT_W];
  end

  // Per-stage accumulators, each with its own enable
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign acc_en[g] = summing && (stage == STAGE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         acc_q[g] <= '0;
      else if (acc_en[g]) acc_q[g] <= acc_d;
    end

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_FINISH && stage == STAGE_W'(g)) |=> (acc_q[g] == '0));

    // R7
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((act == ACT_ADD || act == ACT_FINISH) && stage == STAGE_W'(g))
      |=> $stable(acc_q[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result_q <= '0;
    else if (result_en) result_q <= result_d;
  end

  assign result = result_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (summing && prod[ACC_W-1] == acc_q[stage][ACC_W-1])
    |-> (sum[ACC_W-1] == prod[ACC_W-1]));

  // R7
  pass_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_PASS) |=> (result[SMP_W-1:0] == $past(sample)));

endmodule

// File: rtl/phase_weighted_accum.sv
`timescale 1ns/1ps
module phase_weighted_accum
  import pwa_pkg::*;
#(
  parameter int unsigned SMP_W   = 16,
  parameter int unsigned STAGE_W = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            smp_valid,
  input  logic signed [SMP_W-1:0]         smp_i,
  input  logic signed [SMP_W-1:0]         smp_q,
  input  logic [STAGE_W-1:0]              smp_stage,
  input  logic [PH_W-1:0]                 smp_phase,
  input  logic [PH_W-1:0]                 phase_count,
  output logic                            res_valid,
  output logic [STAGE_W-1:0]              res_stage,
  output logic signed [SMP_W+GUARD_W-1:0] res_i,
  output logic signed [SMP_W+GUARD_W-1:0] res_q,
  output logic                            phase_err
);

  localparam int unsigned LANES = 2;
  localparam int unsigned OUT_W = SMP_W + GUARD_W;

  logic                    rst_n_s;
  logic signed [WGT_W-1:0] weight;
  logic                    phase_ok;
  logic                    phase_last;
  act_e                    act;
  logic signed [SMP_W-1:0] lane_in  [LANES];
  logic signed [OUT_W-1:0] lane_out [LANES];

  pwa_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  pwa_weight_rom u_rom (
    .count      (phase_count),
    .phase      (smp_phase),
    .weight     (weight),
    .phase_ok   (phase_ok),
    .phase_last (phase_last)
  );

  pwa_ctrl #(.STAGE_W(STAGE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .smp_valid  (smp_valid),
    .smp_stage  (smp_stage),
    .count      (phase_count),
    .phase_ok   (phase_ok),
    .phase_last (phase_last),
    .act        (act),
    .res_valid  (res_valid),
    .res_stage  (res_stage),
    .phase_err  (phase_err)
  );

  assign lane_in[0] = smp_i;
  assign lane_in[1] = smp_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pwa_lane #(.SMP_W(SMP_W), .STAGE_W(STAGE_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .act    (act),
      .stage  (smp_stage),
      .sample (lane_in[l]),
      .weight (weight),
      .result (lane_out[l])
    );
  end

  assign res_i = lane_out[0];
  assign res_q = lane_out[1];

endmodule

// File: tb/sim_phase_weighted_accum.sv
`timescale 1ns/1ps
module sim_phase_weighted_accum;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               smp_valid;
  logic signed [15:0] smp_i, smp_q;
  logic [1:0]         smp_stage;
  logic [2:0]         smp_phase;
  logic [2:0]         phase_count;
  logic               res_valid;
  logic [1:0]         res_stage;
  logic signed [18:0] res_i, res_q;
  logic               phase_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  longint m_i [4];
  longint m_q [4];
  bit     m_err;

  always #2.5 clk = ~clk;

  phase_weighted_accum u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .smp_stage(smp_stage), .smp_phase(smp_phase), .phase_count(phase_count),
    .res_valid(res_valid), .res_stage(res_stage), .res_i(res_i), .res_q(res_q),
    .phase_err(phase_err)
  );

  function automatic logic [39:0] mk(int n, int s, int k, int i, int q);
    return {3'(n), 2'(s), 3'(k), 16'(i), 16'(q)};
  endfunction

  localparam int NV = 32;
  localparam logic [39:0] VEC [NV] = '{
    mk(2,0,0,1000,-200), mk(2,0,1,300,50),
    mk(2,1,0,5,7), mk(2,2,0,-9,4), mk(2,1,1,2,3), mk(2,2,1,1,-1),
    mk(3,3,0,900,-30), mk(3,3,1,300,60), mk(3,3,2,-600,90),
    mk(4,0,0,1200,5), mk(4,0,1,777,-8), mk(4,0,2,-400,11), mk(4,0,3,-555,2),
    mk(5,1,0,100,-100), mk(5,1,1,200,-200), mk(5,1,2,300,300), mk(5,1,3,-400,400),
    mk(5,1,4,500,-500),
    mk(6,2,0,31000,-31000), mk(6,2,1,-12000,12000), mk(6,2,2,7,-7), mk(6,2,3,20000,1),
    mk(6,2,4,-3,3), mk(6,2,5,9,-9),
    mk(7,3,0,1,2), mk(7,3,1,3,4), mk(7,3,2,5,6), mk(7,3,3,7,8), mk(7,3,4,9,10),
    mk(7,3,5,11,12), mk(7,3,6,13,14),
    mk(0,2,5,-1234,77)
  };

  function automatic longint wgt(int n, int k);
    real c;
    c = $cos(2.0 * 3.141592653589793 * k / n) * 32768.0;
    return longint'($rtoi(c >= 0.0 ? c + 0.5 : c - 0.5));
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 4; s++) begin m_i[s] = 0; m_q[s] = 0; end
    m_err = 0;
  endtask

  // Drive one cycle of input, then check the registered outputs.
  task automatic step(bit v, int n, int s, int k, int i, int q, string tag);
    bit     ev;
    longint ei, eq, w;
    @(negedge clk);
    smp_valid = v; phase_count = 3'(n); smp_stage = 2'(s); smp_phase = 3'(k);
    smp_i = 16'(i); smp_q = 16'(q);
    ev = 0; ei = 0; eq = 0;
    if (v) begin
      if (n == 0) begin
        ev = 1; ei = longint'(smp_i); eq = longint'(smp_q);
      end else if (k >= n) begin
        m_err = 1;
      end else begin
        w = wgt(n, k);
        m_i[s] += longint'(smp_i) * w;
        m_q[s] += longint'(smp_q) * w;
        if (k == n - 1) begin
          ev = 1; ei = m_i[s] >>> 15; eq = m_q[s] >>> 15;
          m_i[s] = 0; m_q[s] = 0;
        end
      end
    end
    @(posedge clk); #1;
    check("R5/R6 res_valid", longint'(res_valid), longint'(ev));
    if (ev) begin
      check("R5 res_stage", longint'(res_stage), longint'(s));
      check({tag, " res_i"}, longint'(res_i), ei);
      check({tag, " res_q"}, longint'(res_q), eq);
    end
    check("R8 phase_err", longint'(phase_err), longint'(m_err));
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 res_valid in reset", longint'(res_valid), 0);
    check("R1 phase_err in reset", longint'(phase_err), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    logic [39:0] v;
    rst_n = 0; smp_valid = 0; smp_i = 0; smp_q = 0;
    smp_stage = 0; smp_phase = 0; phase_count = 0;
    model_clear();
    do_reset();

    // Vector table walk
    for (int idx = 0; idx < NV; idx++) begin
      v = VEC[idx];
      if (v[39:37] == 3'd0)          tag = "R7";
      else if (idx >= 2 && idx <= 5) tag = "R4";
      else if (v[39:37] == 3'd2)     tag = "R3";
      else                           tag = "R2";
      step(1, int'(v[39:37]), int'(v[36:35]), int'(v[34:32]),
           int'($signed(v[31:16])), int'($signed(v[15:0])), tag);
    end

    // R6: idle cycles give no result
    step(0, 2, 0, 1, 0, 0, "R6");
    step(0, 3, 1, 2, 0, 0, "R6");

    // R5: a second point on the same stage starts fresh
    step(1, 2, 0, 0, 50, 60, "R5");
    step(1, 2, 0, 1, 20, 70, "R5");

    // R7: pass-through in the middle of an open point leaves its sum alone
    step(1, 2, 1, 0, 40, -40, "R7");
    step(1, 0, 1, 3, -3, 9, "R7");
    step(1, 2, 1, 1, 15, 5, "R7");

    // R8: out-of-range phase is dropped and the flag sticks
    step(1, 3, 0, 0, 100, 200, "R8");
    step(1, 3, 0, 5, 9999, -9999, "R8");
    step(1, 3, 0, 1, 40, 8, "R8");
    step(1, 3, 0, 3, 1, 1, "R8");
    step(1, 3, 0, 2, 20, 6, "R8");

    // R10: single phase
    step(1, 1, 1, 0, -5, 6, "R10");
    step(1, 1, 1, 1, 77, 77, "R10");
    step(1, 1, 2, 0, 32767, -32768, "R10");

    // R9: full-scale, signs matched to the weights
    for (int k = 0; k < 7; k++) begin
      if (k == 0 || k == 1 || k == 6) step(1, 7, 3, k, -32768, 32767, "R9");
      else                             step(1, 7, 3, k, 32767, -32768, "R9");
    end

    // R3: extremes of the two-phase difference
    step(1, 2, 2, 0, -32768, 32767, "R3");
    step(1, 2, 2, 1, 32767, -32768, "R3");

    // R1: reset drops an open point and clears the flag
    step(1, 2, 3, 0, 500, -500, "R1");
    do_reset();
    check("R1 phase_err after reset", longint'(phase_err), 0);
    step(1, 2, 3, 0, 10, 4, "R1");
    step(1, 2, 3, 1, 3, 9, "R1");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule